// File: doc/BRIEF.md
# Misaligned Access Splitter

This block sits between a load/store requester and a memory port that is 64 bits wide and takes byte enables. Each request carries a byte address, a size of 1, 2, 4 or 8 bytes, a write flag and write data. The block checks whether the address is a multiple of the size. An aligned request goes to memory as one reference. A misaligned request either fails at once with a trap flag, or, when the `split_en` mode input is high, becomes two references whose data is steered into place. Loads are merged into one right-justified result.

Only one request is in flight at a time. The controller moves through six states. `S_IDLE` accepts a request. It goes to `S_DONE` for a trapped access and to `S_LO_REQ` for any other. `S_LO_REQ` waits for `mem_req_ready` and then moves to `S_LO_WAIT`. `S_LO_WAIT` waits for the response. From there it goes to `S_DONE` on an error or when no split is needed, and to `S_HI_REQ` for the second half. `S_HI_REQ` moves to `S_HI_WAIT` on `mem_req_ready`. `S_HI_WAIT` moves to `S_DONE` on the response. `S_DONE` pulses `rsp_valid` for one cycle and returns to `S_IDLE`. A memory error on either half ends the request and is reported with a flag that tells which half failed.

Top module: `misalign_splitter`

## Requirements
- R1: `req_size` encodes the access width as 0=1, 1=2, 2=4 and 3=8 bytes. An access is aligned when `req_addr` modulo that width is zero. An aligned access makes exactly one memory reference.
- R2: With `split_en`=1 a misaligned access makes exactly two references. The first covers the bytes from `req_addr` up to the next multiple of the width. The second covers the remaining bytes. `mem_word` is the byte address divided by 8.
- R3: With `split_en`=0 a misaligned access makes no memory reference. It responds with `rsp_trap`=1 and `rsp_fault`=0, and memory is left unchanged.
- R4: A load returns the accessed bytes in little-endian order, right-justified in `rsp_rdata`, with all higher bytes zero.
- R5: A store changes exactly the bytes from `req_addr` to `req_addr`+width-1. These bytes take the low bytes of `req_wdata` in little-endian order.
- R6: An error on the first reference gives `rsp_fault`=1 and `rsp_fault_hi`=0. The second reference is not issued.
- R7: An error on the second reference gives `rsp_fault`=1 and `rsp_fault_hi`=1. For a store, the first-half bytes remain written.
- R8: `req_ready` is low from the cycle after acceptance until after the single-cycle `rsp_valid` pulse, so only one request is outstanding.
- R9: While `mem_req_ready` is low, `mem_req_valid` stays high and `mem_word` and `mem_be` hold their values.
- R10: After reset `req_ready`=1, `rsp_valid`=0 and `mem_req_valid`=0.
- R11: Each reference's `mem_be` is nonzero and marks only the bytes that reference moves. The enables over one completed access add up to the access width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| split_en | input | 1 | 1: split misaligned accesses, 0: trap them |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | SZ_W | Width code (0..3) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | DATA_W | Store data, right-justified |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Load result, right-justified |
| rsp_trap | output | 1 | Alignment trap |
| rsp_fault | output | 1 | Memory error on some half |
| rsp_fault_hi | output | 1 | The error came from the second half |
| mem_req_valid | output | 1 | Memory reference valid |
| mem_req_ready | input | 1 | Memory accepts reference |
| mem_word | output | ADDR_W-OFF_W | Word index of the reference |
| mem_write | output | 1 | Reference is a write |
| mem_be | output | BYTES | Byte enables |
| mem_wdata | output | DATA_W | Write data in lane position |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_rdata | input | DATA_W | Memory read word |
| mem_rsp_err | input | 1 | Memory error for the reference |

## Verification
The sweeps visit every width at every byte offset over two words, with both modes and both directions. This catches a boundary computed from the word edge instead of the width multiple: such a design would issue one reference for misaligned accesses inside a word, or place the second half's bytes at the wrong offset. A faulty word placed under the first half, and separately under the second half, exposes a design that still issues the second store or reports the wrong half. A stalling memory ready shows whether the address or enables drift before the handshake, and the enable-count check catches masks that overlap or leave gaps between the two halves.

// File: rtl/msplit_pkg.sv
package msplit_pkg;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_LO_REQ  = 3'd1,
        S_LO_WAIT = 3'd2,
        S_HI_REQ  = 3'd3,
        S_HI_WAIT = 3'd4,
        S_DONE    = 3'd5
    } split_state_e;

endpackage

// File: rtl/msplit_planner.sv
// Works out alignment and the two byte spans of an access.
module msplit_planner #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 3,
    parameter int SZ_W   = 2,
    localparam int CNT_W = OFF_W + 1,
    localparam int BYTES = 1 << OFF_W
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [SZ_W-1:0]         code,
    output logic                    misal,
    output logic [ADDR_W-OFF_W-1:0] lo_word,
    output logic [ADDR_W-OFF_W-1:0] hi_word,
    output logic [CNT_W-1:0]        lo_off,
    output logic [CNT_W-1:0]        lo_cnt,
    output logic [CNT_W-1:0]        hi_off,
    output logic [CNT_W-1:0]        hi_cnt,
    output logic [BYTES-1:0]        lo_be,
    output logic [BYTES-1:0]        hi_be
);
    logic [CNT_W-1:0]  width;
    logic [OFF_W-1:0]  width_m1;
    logic [OFF_W-1:0]  rem;
    logic [ADDR_W-1:0] boundary;

    assign width    = CNT_W'(1) << code;
    assign width_m1 = OFF_W'(width - CNT_W'(1));
    assign rem      = addr[OFF_W-1:0] & width_m1;
    assign misal    = |rem;
    assign boundary = (addr | ADDR_W'(width_m1)) + ADDR_W'(1);

    assign lo_word = addr[ADDR_W-1:OFF_W];
    assign hi_word = boundary[ADDR_W-1:OFF_W];
    assign lo_off  = {1'b0, addr[OFF_W-1:0]};
    assign hi_off  = {1'b0, boundary[OFF_W-1:0]};
    assign lo_cnt  = width - {1'b0, rem};
    assign hi_cnt  = {1'b0, rem};

    for (genvar j = 0; j < BYTES; j++) begin : g_be
        localparam logic [CNT_W-1:0] J = CNT_W'(j);
        assign lo_be[j] = (J >= lo_off) && (J < lo_off + lo_cnt);
        assign hi_be[j] = misal && (J >= hi_off) && (J < hi_off + hi_cnt);
    end
endmodule

// File: rtl/msplit_merge.sv
// Steers store bytes to lanes and gathers load bytes into a right-justified result.
module msplit_merge #(
    parameter int DATA_W = 64,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES),
    localparam int CNT_W = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cap_lo,
    input  logic              cap_hi,
    input  logic              sel_hi,
    input  logic [CNT_W-1:0]  lo_off,
    input  logic [CNT_W-1:0]  lo_cnt,
    input  logic [CNT_W-1:0]  hi_off,
    input  logic [CNT_W-1:0]  hi_cnt,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rdata_in,
    output logic [DATA_W-1:0] lane_wdata,
    output logic [DATA_W-1:0] result
);
    logic [7:0] acc_q [BYTES];

    for (genvar i = 0; i < BYTES; i++) begin : g_byte
        localparam logic [CNT_W-1:0] I = CNT_W'(i);
        logic [OFF_W-1:0] rd_lo_src, rd_hi_src, wr_lo_src, wr_hi_src;
        logic             rd_in_lo, rd_in_hi, wr_in_lo, wr_in_hi;

        // gather: result byte i comes from one of the two responses
        assign rd_lo_src = OFF_W'(lo_off + I);
        assign rd_hi_src = OFF_W'(hi_off + I - lo_cnt);
        assign rd_in_lo  = I < lo_cnt;
        assign rd_in_hi  = (I >= lo_cnt) && (I < lo_cnt + hi_cnt);

        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                acc_q[i] <= '0;
            end else if (cap_lo && rd_in_lo) begin
                acc_q[i] <= rdata_in[{rd_lo_src, 3'b000} +: 8];
            end else if (cap_hi && rd_in_hi) begin
                acc_q[i] <= rdata_in[{rd_hi_src, 3'b000} +: 8];
            end
        end
        assign result[i*8 +: 8] = acc_q[i];

        // steer: memory lane i takes a store byte chosen by the active half
        assign wr_lo_src = OFF_W'(I - lo_off);
        assign wr_hi_src = OFF_W'(I - hi_off + lo_cnt);
        assign wr_in_lo  = (I >= lo_off) && (I < lo_off + lo_cnt);
        assign wr_in_hi  = (I >= hi_off) && (I < hi_off + hi_cnt);
        assign lane_wdata[i*8 +: 8] =
            sel_hi ? (wr_in_hi ? wdata[{wr_hi_src, 3'b000} +: 8] : 8'h00)
                   : (wr_in_lo ? wdata[{wr_lo_src, 3'b000} +: 8] : 8'h00);
    end
endmodule

// File: rtl/misalign_splitter.sv
module misalign_splitter
    import msplit_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES),
    localparam int CNT_W = OFF_W + 1,
    localparam int SZ_W  = $clog2(OFF_W + 1),
    localparam int WRD_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              split_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SZ_W-1:0]   req_size,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_trap,
    output logic              rsp_fault,
    output logic              rsp_fault_hi,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [WRD_W-1:0]  mem_word,
    output logic              mem_write,
    output logic [BYTES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    input  logic              mem_rsp_err
);
    split_state_e st, nxt;

    logic [ADDR_W-1:0] addr_q;
    logic [SZ_W-1:0]   code_q;
    logic              wr_q, split_q, trap_q, fault_q, fhi_q;
    logic [DATA_W-1:0] wdata_q;

    logic [ADDR_W-1:0] p_addr;
    logic [SZ_W-1:0]   p_code;
    logic              misal;
    logic [WRD_W-1:0]  lo_word, hi_word;
    logic [CNT_W-1:0]  lo_off, lo_cnt, hi_off, hi_cnt;
    logic [BYTES-1:0]  lo_be, hi_be;
    logic [DATA_W-1:0] merged;
    logic              accept, sel_hi, cap_lo, cap_hi;

    // planner looks at the incoming request while idle, the held one after
    assign p_addr = (st == S_IDLE) ? req_addr : addr_q;
    assign p_code = (st == S_IDLE) ? req_size : code_q;

    msplit_planner #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SZ_W(SZ_W)) u_plan (
        .addr(p_addr), .code(p_code), .misal(misal),
        .lo_word(lo_word), .hi_word(hi_word),
        .lo_off(lo_off), .lo_cnt(lo_cnt), .hi_off(hi_off), .hi_cnt(hi_cnt),
        .lo_be(lo_be), .hi_be(hi_be)
    );

    msplit_merge #(.DATA_W(DATA_W)) u_merge (
        .clk(clk), .rst_n(rst_n), .clr(accept),
        .cap_lo(cap_lo), .cap_hi(cap_hi), .sel_hi(sel_hi),
        .lo_off(lo_off), .lo_cnt(lo_cnt), .hi_off(hi_off), .hi_cnt(hi_cnt),
        .wdata(wdata_q), .rdata_in(mem_rsp_rdata),
        .lane_wdata(mem_wdata), .result(merged)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // transitions
    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:    if (req_valid) nxt = (misal && !split_en) ? S_DONE : S_LO_REQ;
            S_LO_REQ:  if (mem_req_ready) nxt = S_LO_WAIT;
            S_LO_WAIT: if (mem_rsp_valid)
                           nxt = (mem_rsp_err || !split_q) ? S_DONE : S_HI_REQ;
            S_HI_REQ:  if (mem_req_ready) nxt = S_HI_WAIT;
            S_HI_WAIT: if (mem_rsp_valid) nxt = S_DONE;
            S_DONE:    nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready     = (st == S_IDLE);
        accept        = req_valid && (st == S_IDLE);
        sel_hi        = (st == S_HI_REQ);
        mem_req_valid = (st == S_LO_REQ) || (st == S_HI_REQ);
        mem_word      = sel_hi ? hi_word : lo_word;
        mem_be        = sel_hi ? hi_be : lo_be;
        mem_write     = wr_q;
        cap_lo        = (st == S_LO_WAIT) && mem_rsp_valid;
        cap_hi        = (st == S_HI_WAIT) && mem_rsp_valid;
        rsp_valid     = (st == S_DONE);
        rsp_trap      = trap_q;
        rsp_fault     = fault_q;
        rsp_fault_hi  = fhi_q;
        rsp_rdata     = fault_q ? '0 : merged;
    end

    // request context and completion flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            code_q  <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            split_q <= 1'b0;
            trap_q  <= 1'b0;
            fault_q <= 1'b0;
            fhi_q   <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                code_q  <= req_size;
                wr_q    <= req_write;
                wdata_q <= req_wdata;
                split_q <= misal;
                trap_q  <= misal && !split_en;
                fault_q <= 1'b0;
                fhi_q   <= 1'b0;
            end
            if (cap_lo && mem_rsp_err) fault_q <= 1'b1;
            if (cap_hi && mem_rsp_err) begin
                fault_q <= 1'b1;
                fhi_q   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/msplit_checker.sv
module msplit_checker #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES),
    localparam int WRD_W = ADDR_W - OFF_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_trap,
    input logic             rsp_fault,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [WRD_W-1:0] mem_word,
    input logic [BYTES-1:0] mem_be
);
    // R8: an accepted request closes the door for the next cycle
    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8: completion is a single-cycle pulse
    p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8: no memory traffic while a new request could be taken
    p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    // R9: a stalled reference holds still
    p_hold_on_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_word) && $stable(mem_be)));

    // R11: every reference moves at least one byte
    p_be_nonzero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_be != '0));

    // R3: a trapped access never reports a memory fault
    p_trap_no_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_trap) |-> !rsp_fault);
endmodule

bind misalign_splitter msplit_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_misalign_splitter.sv
module sim_misalign_splitter;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 64;
    localparam int ADDR_W = 6;
    localparam int MEMB   = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              split_en = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_size = '0;
    logic              req_write = 1'b0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic              rsp_trap, rsp_fault, rsp_fault_hi;
    logic              mem_req_valid, mem_req_ready, mem_write;
    logic [ADDR_W-4:0] mem_word;
    logic [7:0]        mem_be;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_rsp_valid = 1'b0;
    logic [DATA_W-1:0] mem_rsp_rdata = '0;
    logic              mem_rsp_err = 1'b0;

    int checks = 0;
    int fails  = 0;
    int ref_total = 0;
    int be_total  = 0;
    int cyc = 0;
    int bad_word = -1;
    bit stall = 1'b0;
    logic [7:0] mem_b [MEMB];
    logic [7:0] shd   [MEMB];

    always #(CLK_PERIOD/2) clk = ~clk;

    misalign_splitter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .split_en(split_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_trap(rsp_trap),
        .rsp_fault(rsp_fault), .rsp_fault_hi(rsp_fault_hi),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_word(mem_word), .mem_write(mem_write), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .mem_rsp_err(mem_rsp_err)
    );

    assign mem_req_ready = !stall || cyc[0];

    // memory model: one-cycle response, error on the chosen word, writes blocked there
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            mem_rsp_valid <= 1'b0;
            for (int k = 0; k < MEMB; k++) mem_b[k] <= 8'(k * 7 + 3);
        end else begin
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                logic [DATA_W-1:0] rd;
                logic              err;
                err = (int'(mem_word) == bad_word);
                for (int b = 0; b < 8; b++) rd[b*8 +: 8] = mem_b[int'(mem_word)*8 + b];
                ref_total     <= ref_total + 1;
                be_total      <= be_total + $countones(mem_be);
                mem_rsp_valid <= 1'b1;
                mem_rsp_err   <= err;
                mem_rsp_rdata <= err ? '0 : rd;
                if (mem_write && !err)
                    for (int b = 0; b < 8; b++)
                        if (mem_be[b]) mem_b[int'(mem_word)*8 + b] <= mem_wdata[b*8 +: 8];
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    task automatic access(input bit sp, input bit wr, input int addr, input int code,
                          input logic [63:0] wd);
        int sz, bnd, lo_w, hi_w, n1, exp_refs, exp_be, r0, b0, guard, diff;
        bit misal, trap, f_lo, f_hi;
        logic [63:0] exp_d;
        sz    = 1 << code;
        misal = (addr % sz) != 0;
        bnd   = (addr / sz + 1) * sz;
        lo_w  = addr / 8;
        hi_w  = bnd / 8;
        n1    = misal ? bnd - addr : sz;
        trap  = misal && !sp;
        f_lo  = !trap && (lo_w == bad_word);
        f_hi  = !trap && !f_lo && misal && (hi_w == bad_word);
        exp_refs = trap ? 0 : (f_lo ? 1 : (misal ? 2 : 1));
        exp_be   = trap ? 0 : (f_lo ? n1 : sz);
        exp_d = '0;
        for (int k = 0; k < sz; k++) exp_d[k*8 +: 8] = shd[addr + k];
        r0 = ref_total;
        b0 = be_total;

        @(negedge clk);
        chk("R8 ready while idle", 64'(req_ready), 64'd1);
        split_en  = sp;
        req_valid = 1'b1;
        req_addr  = ADDR_W'(addr);
        req_size  = 2'(code);
        req_write = wr;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 busy after accept", 64'(req_ready), 64'd0);
        guard = 0;
        while (!rsp_valid && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        chk("R8 response arrives", 64'(rsp_valid), 64'd1);
        chk("R3 trap flag", 64'(rsp_trap), 64'(trap));
        chk(f_hi ? "R7 fault flag" : "R6 fault flag", 64'(rsp_fault), 64'(f_lo || f_hi));
        chk("R7 fault half", 64'(rsp_fault_hi), 64'(f_hi));
        chk(trap ? "R3 no reference" : (misal ? "R2 two references" : "R1 one reference"),
            64'(ref_total - r0), 64'(exp_refs));
        chk("R11 enable total", 64'(be_total - b0), 64'(exp_be));
        if (!wr && !trap && !f_lo && !f_hi)
            chk(stall ? "R9 load data under stall" : "R4 load data", rsp_rdata, exp_d);
        if (wr && !trap) begin
            for (int k = 0; k < sz; k++) begin
                bit in_lo;
                in_lo = !misal || (addr + k < bnd);
                if (in_lo ? !f_lo : !(f_lo || f_hi)) shd[addr + k] = wd[k*8 +: 8];
            end
        end
        @(negedge clk);
        chk("R8 pulse ends", 64'(rsp_valid), 64'd0);
        chk("R8 ready again", 64'(req_ready), 64'd1);
        diff = 0;
        for (int k = 0; k < MEMB; k++) if (mem_b[k] !== shd[k]) diff++;
        chk(f_hi ? "R7 memory image" : (trap ? "R3 memory image" : "R5 memory image"),
            64'(diff), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL R8 watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int n;
        n = 0;
        for (int k = 0; k < MEMB; k++) shd[k] = 8'(k * 7 + 3);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 reset ready", 64'(req_ready), 64'd1);
        chk("R10 reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R10 reset mem_req_valid", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;

        // every width at every offset, both modes, loads and stores
        for (int sp = 0; sp < 2; sp++)
            for (int wr = 0; wr < 2; wr++)
                for (int code = 0; code < 4; code++)
                    for (int a = 0; a < 16; a++) begin
                        n++;
                        access(sp[0], wr[0], a, code, {8{8'(n)}} ^ 64'hF0E1D2C3B4A59687);
                    end

        // faulty word 2 under either half, stalling memory
        bad_word = 2;
        stall    = 1'b1;
        for (int wr = 0; wr < 2; wr++)
            for (int code = 0; code < 4; code++)
                for (int a = 8; a < 32; a++) begin
                    n++;
                    access(1'b1, wr[0], a, code, {8{8'(n * 3)}} ^ 64'h1122334455667788);
                end

        summary();
        $finish;
    end
endmodule